// File: doc/BRIEF.md
# Stack and Relative Call/Return Unit

This block holds the program-flow and stack logic of a small 8-bit processor core. It keeps a 16-bit stack pointer, visible as two byte registers, and runs the stack instructions: a byte push from a register, a byte pop into a register, a relative jump, a relative call that saves the return address on the stack, and a return that restores it. It drives the address, write data and strobes of a byte-wide data memory port. The port's read data is expected to come back in the same cycle as the address.

The core presents one instruction word at a time with `instr_valid`, together with its own program counter and the value of the source register. Push, pop and jump finish in the cycle they are issued. Call and return need two memory accesses and the port allows one per clock. They therefore take two cycles, and `busy` is high during the second one. A new program counter is presented with `pc_load`. A popped byte is handed to the register file with `pop_we` and a register index. The core can overwrite either byte of the stack pointer at any time.

Top module: `stack_flow_unit`

## Requirements
- R1: After reset the stack pointer reads 0x0000, `busy` is low, and `mem_we`, `mem_re`, `pc_load` and `pop_we` are low.
- R2: A push (instr[15:9]=1001001, instr[3:0]=1111) drives `mem_we` with `mem_addr` equal to the stack pointer and `mem_wdata` equal to `reg_rdata` in its issue cycle, and the pointer then drops by one.
- R3: A pop (instr[15:9]=1001000, instr[3:0]=1111) first raises the pointer by one and reads that address. In the issue cycle it asserts `mem_re` and `pop_we`, sets `pop_reg` to instr[8:4] and `pop_data` to the byte read.
- R4: A jump (instr[15:12]=1100) asserts `pc_load` in its issue cycle with `pc_next` = `pc_in` + offset + 1. The offset is instr[11:0] as a two's complement value: a field above 2047 means the field minus 4096.
- R5: A call (instr[15:12]=1101) writes `pc_in`[7:0] at the stack pointer in the issue cycle. In the next cycle it writes `pc_in`[15:8] one address lower, holds `busy` high, and loads the jump target. The pointer ends two lower.
- R6: A return (instr = 0x9508) reads the high byte at pointer+1 in the issue cycle. In the next cycle, with `busy` high, it reads the low byte at pointer+2 and loads `pc_next` = {high, low} + 1. The pointer ends two higher.
- R7: A write strobe for the low or high pointer byte replaces only that byte with `sp_wdata`. When it falls in the same cycle as a push, pop, call or return step, it is applied on top of the already adjusted pointer. The memory address of that step still uses the old pointer.
- R8: `instr_valid` is ignored while `busy` is high. Any other instruction word causes no memory access, no `pc_load` and no change to the pointer.
- R9: Pointer and program-counter arithmetic wraps modulo 2^16. A push at 0x0000 leaves 0xFFFF.
- R10: The memory port never has `mem_we` and `mem_re` high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is presented this cycle |
| instr | input | 16 | Instruction word |
| pc_in | input | 16 | Address of the presented instruction |
| reg_rdata | input | 8 | Source register value for a push |
| mem_rdata | input | 8 | Same-cycle read data of the data memory |
| sp_lo_we | input | 1 | Replace the low byte of the stack pointer |
| sp_hi_we | input | 1 | Replace the high byte of the stack pointer |
| sp_wdata | input | 8 | Byte for a pointer byte write |
| pc_next | output | 16 | New program counter |
| pc_load | output | 1 | `pc_next` is valid |
| mem_addr | output | 16 | Data memory address |
| mem_wdata | output | 8 | Data memory write byte |
| mem_we | output | 1 | Data memory write strobe |
| mem_re | output | 1 | Data memory read strobe |
| pop_data | output | 8 | Byte popped for the register file |
| pop_reg | output | 5 | Destination register index of a pop |
| pop_we | output | 1 | Register write strobe for a pop |
| busy | output | 1 | Second cycle of a call or return |
| sp_lo | output | 8 | Stack pointer low byte |
| sp_hi | output | 8 | Stack pointer high byte |

## Verification
Two things can fall in the same clock. A pointer byte write can coincide with the pointer step of a push, pop, call or return. A new instruction can also be presented during the busy second cycle of a call or return. The bench drives both cases on purpose, and the random phase also puts byte strobes on about one operation in eight. For a collision it checks that the memory address was taken from the old pointer and that the final pointer is the stepped value with the written byte replaced. For an instruction presented while busy, it checks that the pointer moved by exactly two and that no extra memory write took place.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
   typedef enum logic [2:0] {
      OP_NONE,
      OP_PUSH,
      OP_POP,
      OP_JMP,
      OP_CALL,
      OP_RET
   } sfu_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CALL2,
      ST_RET2
   } sfu_st_e;
endpackage

// File: rtl/sfu_decode.sv
module sfu_decode
   import sfu_pkg::*;
#(
   parameter int IW   = 16,
   parameter int RW   = 5,
   parameter int OFFW = 12
) (
   input  logic [IW-1:0]   instr,
   output sfu_op_e         op,
   output logic [RW-1:0]   reg_idx,
   output logic [OFFW-1:0] offset
);
   localparam int RLSB = 4;
   localparam logic [3:0]  JMP_PFX  = 4'b1100;
   localparam logic [3:0]  CALL_PFX = 4'b1101;
   localparam logic [6:0]  PUSH_PFX = 7'b1001001;
   localparam logic [6:0]  POP_PFX  = 7'b1001000;
   localparam logic [3:0]  STK_SFX  = 4'b1111;
   localparam logic [15:0] RET_WORD = 16'h9508;

   if (IW != 16) begin : g_bad_iw
      $error("sfu_decode: instruction width must be 16");
   end
   if (RW + RLSB + 7 != IW) begin : g_bad_rw
      $error("sfu_decode: register field width mismatch");
   end
   if (OFFW != 12) begin : g_bad_off
      $error("sfu_decode: offset field must be 12 bits");
   end

   assign reg_idx = instr[RLSB +: RW];
   assign offset  = instr[OFFW-1:0];

   always_comb begin
      op = OP_NONE;
      if (instr == RET_WORD)
         op = OP_RET;
      else if (instr[15:12] == JMP_PFX)
         op = OP_JMP;
      else if (instr[15:12] == CALL_PFX)
         op = OP_CALL;
      else if (instr[15:9] == PUSH_PFX && instr[3:0] == STK_SFX)
         op = OP_PUSH;
      else if (instr[15:9] == POP_PFX && instr[3:0] == STK_SFX)
         op = OP_POP;
   end
endmodule

// File: rtl/sfu_sp_reg.sv
module sfu_sp_reg #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   input  logic          lo_we,
   input  logic          hi_we,
   input  logic [DW-1:0] wdata,
   output logic [AW-1:0] sp_q
);
   localparam logic [AW-1:0] ONE = 1;

   if (AW != 2 * DW) begin : g_bad_w
      $error("sfu_sp_reg: pointer must be two data bytes wide");
   end

   logic [AW-1:0] sp_d;

   always_comb begin
      sp_d = sp_q;
      if (inc)
         sp_d = sp_q + ONE;
      else if (dec)
         sp_d = sp_q - ONE;
      if (lo_we)
         sp_d[DW-1:0] = wdata;
      if (hi_we)
         sp_d[AW-1:DW] = wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         sp_q <= '0;
      else
         sp_q <= sp_d;
   end

   // R2
   sp_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && !lo_we && !hi_we) |=> (sp_q == $past(sp_q) - ONE));

   // R3
   sp_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec && !lo_we && !hi_we) |=> (sp_q == $past(sp_q) + ONE));

   // R7
   lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_we |=> (sp_q[DW-1:0] == $past(wdata)));
endmodule

// File: rtl/sfu_seq.sv
module sfu_seq
   import sfu_pkg::*;
#(
   parameter int AW   = 16,
   parameter int DW   = 8,
   parameter int RW   = 5,
   parameter int OFFW = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            instr_valid,
   input  sfu_op_e         op,
   input  logic [RW-1:0]   reg_idx,
   input  logic [OFFW-1:0] offset,
   input  logic [AW-1:0]   pc_in,
   input  logic [DW-1:0]   reg_rdata,
   input  logic [DW-1:0]   mem_rdata,
   input  logic [AW-1:0]   sp,
   output logic [AW-1:0]   pc_next,
   output logic            pc_load,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   output logic            mem_we,
   output logic            mem_re,
   output logic [DW-1:0]   pop_data,
   output logic [RW-1:0]   pop_reg,
   output logic            pop_we,
   output logic            sp_inc,
   output logic            sp_dec,
   output logic            busy
);
   localparam logic [AW-1:0] ONE = 1;

   sfu_st_e       st_q;
   logic [DW-1:0] hold_byte_q;
   logic [AW-1:0] hold_pc_q;
   logic [AW-1:0] off_ext;
   logic [AW-1:0] target;
   logic [AW-1:0] sp_above;
   logic          issue;

   if (OFFW < AW) begin : g_sext
      assign off_ext = {{(AW - OFFW){offset[OFFW-1]}}, offset};
   end else begin : g_trunc
      assign off_ext = offset[AW-1:0];
   end

   assign target   = pc_in + off_ext + ONE;
   assign sp_above = sp + ONE;
   assign busy     = (st_q != ST_IDLE);
   assign issue    = instr_valid && !busy;
   assign pop_data = mem_rdata;
   assign pop_reg  = reg_idx;

   always_comb begin
      pc_next   = '0;
      pc_load   = 1'b0;
      mem_addr  = sp;
      mem_wdata = '0;
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      pop_we    = 1'b0;
      sp_inc    = 1'b0;
      sp_dec    = 1'b0;
      unique case (st_q)
         ST_CALL2: begin
            mem_we    = 1'b1;
            mem_wdata = hold_byte_q;
            sp_dec    = 1'b1;
            pc_load   = 1'b1;
            pc_next   = hold_pc_q;
         end
         ST_RET2: begin
            mem_re   = 1'b1;
            mem_addr = sp_above;
            sp_inc   = 1'b1;
            pc_load  = 1'b1;
            pc_next  = {hold_byte_q, mem_rdata} + ONE;
         end
         default: begin
            if (issue) begin
               unique case (op)
                  OP_PUSH: begin
                     mem_we    = 1'b1;
                     mem_wdata = reg_rdata;
                     sp_dec    = 1'b1;
                  end
                  OP_POP: begin
                     mem_re   = 1'b1;
                     mem_addr = sp_above;
                     pop_we   = 1'b1;
                     sp_inc   = 1'b1;
                  end
                  OP_JMP: begin
                     pc_load = 1'b1;
                     pc_next = target;
                  end
                  OP_CALL: begin
                     mem_we    = 1'b1;
                     mem_wdata = pc_in[DW-1:0];
                     sp_dec    = 1'b1;
                  end
                  OP_RET: begin
                     mem_re   = 1'b1;
                     mem_addr = sp_above;
                     sp_inc   = 1'b1;
                  end
                  default: ;
               endcase
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         hold_byte_q <= '0;
         hold_pc_q   <= '0;
      end else if (issue && op == OP_CALL) begin
         st_q        <= ST_CALL2;
         hold_byte_q <= pc_in[AW-1:DW];
         hold_pc_q   <= target;
      end else if (issue && op == OP_RET) begin
         st_q        <= ST_RET2;
         hold_byte_q <= mem_rdata;
      end else begin
         st_q <= ST_IDLE;
      end
   end

   // R10
   one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_we, mem_re}));

   // R5
   call_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op == OP_CALL) |=> (busy && mem_we && pc_load));

   // R6
   ret_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op == OP_RET) |=> (busy && mem_re && pc_load));

   // R8
   busy_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);
endmodule

// File: rtl/stack_flow_unit.sv
module stack_flow_unit
   import sfu_pkg::*;
#(
   parameter int AW   = 16,
   parameter int DW   = 8,
   parameter int IW   = 16,
   parameter int RW   = 5,
   parameter int OFFW = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            instr_valid,
   input  logic [IW-1:0]   instr,
   input  logic [AW-1:0]   pc_in,
   input  logic [DW-1:0]   reg_rdata,
   input  logic [DW-1:0]   mem_rdata,
   input  logic            sp_lo_we,
   input  logic            sp_hi_we,
   input  logic [DW-1:0]   sp_wdata,
   output logic [AW-1:0]   pc_next,
   output logic            pc_load,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   output logic            mem_we,
   output logic            mem_re,
   output logic [DW-1:0]   pop_data,
   output logic [RW-1:0]   pop_reg,
   output logic            pop_we,
   output logic            busy,
   output logic [DW-1:0]   sp_lo,
   output logic [DW-1:0]   sp_hi
);
   sfu_op_e         op;
   logic [RW-1:0]   reg_idx;
   logic [OFFW-1:0] offset;
   logic [AW-1:0]   sp;
   logic            sp_inc;
   logic            sp_dec;

   sfu_decode #(.IW(IW), .RW(RW), .OFFW(OFFW)) u_dec (
      .instr   (instr),
      .op      (op),
      .reg_idx (reg_idx),
      .offset  (offset)
   );

   sfu_sp_reg #(.AW(AW), .DW(DW)) u_sp (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (sp_inc),
      .dec   (sp_dec),
      .lo_we (sp_lo_we),
      .hi_we (sp_hi_we),
      .wdata (sp_wdata),
      .sp_q  (sp)
   );

   sfu_seq #(.AW(AW), .DW(DW), .RW(RW), .OFFW(OFFW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .op          (op),
      .reg_idx     (reg_idx),
      .offset      (offset),
      .pc_in       (pc_in),
      .reg_rdata   (reg_rdata),
      .mem_rdata   (mem_rdata),
      .sp          (sp),
      .pc_next     (pc_next),
      .pc_load     (pc_load),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_we      (mem_we),
      .mem_re      (mem_re),
      .pop_data    (pop_data),
      .pop_reg     (pop_reg),
      .pop_we      (pop_we),
      .sp_inc      (sp_inc),
      .sp_dec      (sp_dec),
      .busy        (busy)
   );

   assign sp_lo = sp[DW-1:0];
   assign sp_hi = sp[AW-1:DW];

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (sp == '0 && !busy));
endmodule

// File: tb/sim_stack_flow_unit.sv
`timescale 1ns/1ps
module sim_stack_flow_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [15:0] instr = '0;
   logic [15:0] pc_in = '0;
   logic [7:0]  reg_rdata = '0;
   logic [7:0]  mem_rdata;
   logic        sp_lo_we = 1'b0;
   logic        sp_hi_we = 1'b0;
   logic [7:0]  sp_wdata = '0;
   logic [15:0] pc_next;
   logic        pc_load;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_we;
   logic        mem_re;
   logic [7:0]  pop_data;
   logic [4:0]  pop_reg;
   logic        pop_we;
   logic        busy;
   logic [7:0]  sp_lo;
   logic [7:0]  sp_hi;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   logic [15:0] msp = '0;
   logic [7:0]  dmem   [0:65535];
   logic [7:0]  shadow [0:65535];

   always #4 clk = ~clk;

   stack_flow_unit u0 (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .pc_in(pc_in), .reg_rdata(reg_rdata), .mem_rdata(mem_rdata),
      .sp_lo_we(sp_lo_we), .sp_hi_we(sp_hi_we), .sp_wdata(sp_wdata),
      .pc_next(pc_next), .pc_load(pc_load), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
      .pop_data(pop_data), .pop_reg(pop_reg), .pop_we(pop_we),
      .busy(busy), .sp_lo(sp_lo), .sp_hi(sp_hi)
   );

   assign mem_rdata = dmem[mem_addr];
   always @(posedge clk) if (mem_we) dmem[mem_addr] <= mem_wdata;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // 0 none, 1 push, 2 pop, 3 jmp, 4 call, 5 ret
   function automatic int kind_of(input logic [15:0] w);
      if (w == 16'h9508) return 5;
      if (w[15:12] == 4'hC) return 3;
      if (w[15:12] == 4'hD) return 4;
      if (w[15:9] == 7'b1001001 && w[3:0] == 4'hF) return 1;
      if (w[15:9] == 7'b1001000 && w[3:0] == 4'hF) return 2;
      return 0;
   endfunction

   function automatic logic [15:0] jump_to(input logic [15:0] pc, input logic [11:0] f);
      int o;
      o = (f > 12'd2047) ? int'(f) - 4096 : int'(f);
      return pc + 16'(o) + 16'd1;
   endfunction

   task automatic step_op(input logic [15:0] w, input logic [15:0] pc,
                          input logic [7:0] rd, input bit lw, input bit hw,
                          input logic [7:0] wv, input bit poke);
      int k;
      logic [15:0] nsp;
      logic [15:0] a;
      logic [7:0]  hi;
      string tag;
      k = kind_of(w);
      hi = '0;
      @(negedge clk);
      instr_valid = 1'b1; instr = w; pc_in = pc; reg_rdata = rd;
      sp_lo_we = lw; sp_hi_we = hw; sp_wdata = wv;
      #1;
      chk("R10", "we/re exclusive", {31'd0, mem_we & mem_re}, 32'd0);
      nsp = msp;
      a = msp + 16'd1;
      case (k)
         1: begin
            tag = "R2";
            chk("R2", "push we", {31'd0, mem_we}, 32'd1);
            chk("R2", "push addr", {16'd0, mem_addr}, {16'd0, msp});
            chk("R2", "push data", {24'd0, mem_wdata}, {24'd0, rd});
            shadow[msp] = rd;
            nsp = msp - 16'd1;
         end
         2: begin
            tag = "R3";
            chk("R3", "pop re", {31'd0, mem_re}, 32'd1);
            chk("R3", "pop addr", {16'd0, mem_addr}, {16'd0, a});
            chk("R3", "pop we", {31'd0, pop_we}, 32'd1);
            chk("R3", "pop reg", {27'd0, pop_reg}, {27'd0, w[8:4]});
            chk("R3", "pop data", {24'd0, pop_data}, {24'd0, shadow[a]});
            nsp = a;
         end
         3: begin
            tag = "R4";
            chk("R4", "jmp load", {31'd0, pc_load}, 32'd1);
            chk("R4", "jmp target", {16'd0, pc_next}, {16'd0, jump_to(pc, w[11:0])});
         end
         4: begin
            tag = "R5";
            chk("R5", "call we1", {31'd0, mem_we}, 32'd1);
            chk("R5", "call addr1", {16'd0, mem_addr}, {16'd0, msp});
            chk("R5", "call low byte", {24'd0, mem_wdata}, {24'd0, pc[7:0]});
            chk("R5", "call no load yet", {31'd0, pc_load}, 32'd0);
            shadow[msp] = pc[7:0];
            nsp = msp - 16'd1;
         end
         5: begin
            tag = "R6";
            chk("R6", "ret re1", {31'd0, mem_re}, 32'd1);
            chk("R6", "ret addr1", {16'd0, mem_addr}, {16'd0, a});
            hi = shadow[a];
            nsp = a;
         end
         default: begin
            tag = "R8";
            chk("R8", "other: no access", {30'd0, mem_we, mem_re}, 32'd0);
            chk("R8", "other: no load", {31'd0, pc_load}, 32'd0);
         end
      endcase
      if (lw) begin nsp[7:0] = wv; tag = "R7"; end
      if (hw) begin nsp[15:8] = wv; tag = "R7"; end
      msp = nsp;
      if (k == 4 || k == 5) begin
         @(negedge clk);
         instr_valid = poke; instr = 16'h93FF; reg_rdata = 8'hEE;
         sp_lo_we = 1'b0; sp_hi_we = 1'b0;
         #1;
         chk("R10", "we/re exclusive", {31'd0, mem_we & mem_re}, 32'd0);
         if (k == 4) begin
            chk("R5", "call busy", {31'd0, busy}, 32'd1);
            chk("R5", "call we2", {31'd0, mem_we}, 32'd1);
            chk("R5", "call addr2", {16'd0, mem_addr}, {16'd0, msp});
            chk("R5", "call high byte", {24'd0, mem_wdata}, {24'd0, pc[15:8]});
            chk("R5", "call load", {31'd0, pc_load}, 32'd1);
            chk("R5", "call target", {16'd0, pc_next}, {16'd0, jump_to(pc, w[11:0])});
            shadow[msp] = pc[15:8];
            msp = msp - 16'd1;
         end else begin
            a = msp + 16'd1;
            chk("R6", "ret busy", {31'd0, busy}, 32'd1);
            chk("R6", "ret re2", {31'd0, mem_re}, 32'd1);
            chk("R6", "ret addr2", {16'd0, mem_addr}, {16'd0, a});
            chk("R6", "ret load", {31'd0, pc_load}, 32'd1);
            chk("R6", "ret target", {16'd0, pc_next}, {16'd0, {hi, shadow[a]} + 16'd1});
            msp = a;
         end
      end
      @(negedge clk);
      instr_valid = 1'b0; sp_lo_we = 1'b0; sp_hi_we = 1'b0;
      #1;
      chk(poke ? "R8" : tag, "pointer", {16'd0, sp_hi, sp_lo}, {16'd0, msp});
      chk(tag, "idle after", {31'd0, busy}, 32'd0);
   endtask

   function automatic logic [15:0] push_w(input logic [4:0] r);
      return {7'b1001001, r, 4'hF};
   endfunction
   function automatic logic [15:0] pop_w(input logic [4:0] r);
      return {7'b1001000, r, 4'hF};
   endfunction

   initial begin
      logic [15:0] w;
      int sel;
      void'($urandom(32'h5A17));
      for (int i = 0; i < 65536; i++) begin dmem[i] = 8'h00; shadow[i] = 8'h00; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "reset pointer", {16'd0, sp_hi, sp_lo}, 32'd0);
      chk("R1", "reset busy", {31'd0, busy}, 32'd0);
      chk("R1", "reset strobes", {28'd0, mem_we, mem_re, pc_load, pop_we}, 32'd0);

      // R9 wrap below zero and back
      step_op(push_w(5'd3), 16'h0100, 8'hA5, 0, 0, 8'h00, 0);
      chk("R9", "push wraps", {16'd0, sp_hi, sp_lo}, 32'h0000FFFF);
      step_op(pop_w(5'd9), 16'h0101, 8'h00, 0, 0, 8'h00, 0);
      chk("R9", "pop wraps", {16'd0, sp_hi, sp_lo}, 32'h00000000);
      // never-written location pops zero
      step_op(pop_w(5'd1), 16'h0102, 8'h00, 0, 0, 8'h00, 0);
      // R4 offset corners
      step_op(16'hC7FF, 16'h1000, 8'h00, 0, 0, 8'h00, 0);
      step_op(16'hC800, 16'h1000, 8'h00, 0, 0, 8'h00, 0);
      step_op(16'hCFFF, 16'h1000, 8'h00, 0, 0, 8'h00, 0);
      step_op(16'hC000, 16'hFFFF, 8'h00, 0, 0, 8'h00, 0);
      // R7 set pointer with an unrelated word, then collide with a push
      step_op(16'h0000, 16'h0000, 8'h00, 1, 1, 8'h08, 0);
      step_op(push_w(5'd2), 16'h0010, 8'h3C, 1, 0, 8'h55, 0);
      chk("R7", "collision result", {16'd0, sp_hi, sp_lo}, 32'h00000855);
      step_op(16'h0000, 16'h0000, 8'h00, 1, 1, 8'h04, 0);
      // R5/R6 call then return, with a poke during busy
      step_op(16'hD010, 16'h1234, 8'h00, 0, 0, 8'h00, 1);
      step_op(16'h9508, 16'h1245, 8'h00, 0, 0, 8'h00, 1);
      step_op(16'hD800, 16'h0003, 8'h00, 0, 0, 8'h00, 0);
      step_op(16'h9508, 16'hF804, 8'h00, 0, 0, 8'h00, 0);
      // R8 decoys close to valid encodings
      step_op(16'h9509, 16'h0000, 8'h00, 0, 0, 8'h00, 0);
      step_op(16'h93FE, 16'h0000, 8'h11, 0, 0, 8'h00, 0);

      for (int n = 0; n < 400; n++) begin
         sel = $urandom_range(0, 9);
         case (sel)
            0, 1: w = push_w(5'($urandom));
            2, 3: w = pop_w(5'($urandom));
            4: w = {4'hC, 12'($urandom)};
            5: w = {4'hD, 12'($urandom)};
            6: w = 16'h9508;
            default: w = 16'($urandom);
         endcase
         step_op(w, 16'($urandom), 8'($urandom),
                 ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                 8'($urandom), $urandom_range(0, 1) == 1);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule